// File: doc/BRIEF.md
# Rotating Register Stack with Tag Word

This block holds the working registers of a floating-point unit as a ring of eight 80-bit entries. A 3-bit top pointer picks the entry that software sees as the top. Any logical register number ST(i) is turned into a physical index by adding it to the pointer modulo the ring size. Each physical entry carries a 2-bit tag. The tags are packed into a 16-bit tag word, and that word, together with the pointer, is exposed for the status and environment logic.

One operation is accepted per clock, qualified by `op_valid`. The operations are:
- initialise
- push
- pop
- read ST(i)
- write ST(i)
- exchange ST(0) with ST(i)
- pointer increment
- pointer decrement

Stack overflow and underflow are detected from the tags. Each raises a fault pulse, a direction bit and an invalid-operation pulse in the same cycle as the operation. The tag of every value written is derived from the value itself, by checking for zero and for special encodings of the extended format.

Top module: `rot_regstack`

## Requirements
- R1: Reset and the initialise operation (op code 0) set `top_ptr` to 0 and mark every entry empty, so `tag_word` reads FFFFh.
- R2: A push (op code 1) first moves `top_ptr` down by one modulo 8 and then writes `wr_data` into the new top. After initialisation the first push lands in physical entry 7 and the second in entry 6.
- R3: A pop (op code 2) marks the current top entry empty and then moves `top_ptr` up by one modulo 8. A pop of an empty top still moves the pointer.
- R4: ST(i) selects physical entry (`top_ptr` + i) mod 8. A read (op code 3) shows that entry on `rd_data`, combinationally in the operation cycle. An empty entry reads as the indefinite value FFFF_C000000000000000h.
- R5: Physical entry p owns bits [2p+1:2p] of `tag_word`. The tag codes are: 00 valid, 01 zero, 10 special (all-ones exponent, denormal, or clear integer bit 63), 11 empty. For example, one non-zero push from the initial state gives 3FFFh, and a following push of zero gives 1FFFh.
- R6: A push whose target entry is not empty is an overflow. The pointer still rotates, the indefinite value is written with tag 10, and `stk_fault` and `c1_dir` both pulse high.
- R7: A pop of an empty top, or a read of an empty ST(i), is an underflow. It pulses `stk_fault` with `c1_dir` low.
- R8: `inv_op` pulses whenever `stk_fault` pulses.
- R9: An exchange (op code 5) swaps the data and tags of ST(0) and ST(i). If either operand is empty, it raises an underflow and leaves both entries and all tags unchanged.
- R10: An increment (op code 6) or decrement (op code 7) moves `top_ptr` by one modulo 8, changes no tag, and raises no fault.
- R11: A write (op code 4) replaces ST(i) with `wr_data` and its derived tag, whether or not the entry was empty. It leaves `top_ptr` unchanged and raises no fault.
- R12: With `op_valid` low nothing changes and no fault output is high. Fault outputs are high only in the cycle of the operation that caused them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Qualifies the operation this cycle |
| op_code | input | 3 | Operation code (see requirements) |
| st_idx | input | 3 | Logical register number i |
| wr_data | input | 80 | Value for push or write |
| rd_data | output | 80 | Contents of ST(i), indefinite if empty |
| top_ptr | output | 3 | Current top pointer |
| tag_word | output | 16 | Packed tags, two bits per physical entry |
| stk_fault | output | 1 | Stack fault pulse |
| c1_dir | output | 1 | Fault direction: 1 overflow, 0 underflow |
| inv_op | output | 1 | Invalid-operation pulse |

## Verification
Pointer rotation and fault reporting fall in the same cycle when a ninth push meets a full ring. The pointer must still step down, and the entry it lands on must take the indefinite value while the fault and direction pulses rise in that same cycle. The bench fills the ring with eight pushes and then pushes once more. It judges the fault pulses, the new pointer, the tag word 8000h and the readback of ST(0) and ST(1) against values worked out by hand.

An exchange with an empty operand, and a pop of an empty top, likewise pair an attempted state change with an underflow. For these, the bench checks that the tags stay put while the fault rises, and that the pop's pointer movement still happens.

// File: rtl/rstk_pkg.sv
package rstk_pkg;

   typedef enum logic [2:0] {
      OP_INIT  = 3'd0,
      OP_PUSH  = 3'd1,
      OP_POP   = 3'd2,
      OP_READ  = 3'd3,
      OP_WRITE = 3'd4,
      OP_XCHG  = 3'd5,
      OP_INC   = 3'd6,
      OP_DEC   = 3'd7
   } op_e;

   localparam logic [1:0] TAG_VALID = 2'b00;
   localparam logic [1:0] TAG_ZERO  = 2'b01;
   localparam logic [1:0] TAG_SPEC  = 2'b10;
   localparam logic [1:0] TAG_EMPTY = 2'b11;

endpackage

// File: rtl/rstk_classify.sv
// Derives the tag of a value from its exponent and significand fields.
module rstk_classify #(
   parameter int EXP_W        = 15,
   parameter int MAN_W        = 64,
   parameter bit EXPLICIT_INT = 1'b1
) (
   input  logic [EXP_W-1:0] exp_f,
   input  logic [MAN_W-1:0] man_f,
   output logic [1:0]       tag
);
   import rstk_pkg::*;

   logic exp_zero, exp_ones, man_zero, unnorm;

   assign exp_zero = (exp_f == '0);
   assign exp_ones = (exp_f == '1);
   assign man_zero = (man_f == '0);

   // Only a format that stores its integer bit can hold an unnormal.
   generate
      if (EXPLICIT_INT) begin : g_explicit
         assign unnorm = !exp_zero && !exp_ones && !man_f[MAN_W-1];
      end else begin : g_implicit
         assign unnorm = 1'b0;
      end
   endgenerate

   always_comb begin
      if (exp_zero && man_zero)
         tag = TAG_ZERO;
      else if (exp_zero || exp_ones || unnorm)
         tag = TAG_SPEC;
      else
         tag = TAG_VALID;
   end

endmodule

// File: rtl/rstk_ptr.sv
// Top pointer and the logical-to-physical address arithmetic.
module rstk_ptr #(
   parameter int PTR_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   input  logic [2:0]       op,
   input  logic [PTR_W-1:0] idx,
   output logic [PTR_W-1:0] top,
   output logic [PTR_W-1:0] top_dn,
   output logic [PTR_W-1:0] top_i
);
   import rstk_pkg::*;

   localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

   logic [PTR_W-1:0] top_up;

   assign top_dn = top - ONE;
   assign top_up = top + ONE;
   assign top_i  = top + idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         top <= '0;
      end else if (fire) begin
         case (op_e'(op))
            OP_INIT:         top <= '0;
            OP_PUSH, OP_DEC: top <= top_dn;
            OP_POP,  OP_INC: top <= top_up;
            default:         top <= top;
         endcase
      end
   end

endmodule

// File: rtl/rstk_fault.sv
// Overflow / underflow decode from the emptiness of the touched entries.
module rstk_fault (
   input  logic       fire,
   input  logic [2:0] op,
   input  logic       empty_top,
   input  logic       empty_dn,
   input  logic       empty_i,
   output logic       ovf,
   output logic       unf
);
   import rstk_pkg::*;

   always_comb begin
      ovf = 1'b0;
      unf = 1'b0;
      if (fire) begin
         case (op_e'(op))
            OP_PUSH: ovf = !empty_dn;
            OP_POP:  unf = empty_top;
            OP_READ: unf = empty_i;
            OP_XCHG: unf = empty_top || empty_i;
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/rstk_store.sv
// Register ring: data entries plus a packed tag word, two write ports
// and a port that marks one entry empty.
module rstk_store #(
   parameter int NREG   = 8,
   parameter int DATA_W = 80,
   localparam int PTR_W = $clog2(NREG),
   localparam int TW_W  = 2 * NREG
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_all,
   input  logic              a_en,
   input  logic [PTR_W-1:0]  a_addr,
   input  logic [DATA_W-1:0] a_data,
   input  logic [1:0]        a_tag,
   input  logic              b_en,
   input  logic [PTR_W-1:0]  b_addr,
   input  logic [DATA_W-1:0] b_data,
   input  logic [1:0]        b_tag,
   input  logic              e_en,
   input  logic [PTR_W-1:0]  e_addr,
   output logic [DATA_W-1:0] q [NREG],
   output logic [TW_W-1:0]   tags
);
   import rstk_pkg::*;

   generate
      for (genvar p = 0; p < NREG; p++) begin : g_ent
         localparam logic [PTR_W-1:0] ME = PTR_W'(p);

         logic hit_a, hit_b, hit_e;
         assign hit_a = a_en && (a_addr == ME);
         assign hit_b = b_en && (b_addr == ME);
         assign hit_e = e_en && (e_addr == ME);

         always_ff @(posedge clk) begin
            if (hit_a)
               q[p] <= a_data;
            else if (hit_b)
               q[p] <= b_data;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               tags[2*p +: 2] <= TAG_EMPTY;
            else if (clr_all)
               tags[2*p +: 2] <= TAG_EMPTY;
            else if (hit_a)
               tags[2*p +: 2] <= a_tag;
            else if (hit_b)
               tags[2*p +: 2] <= b_tag;
            else if (hit_e)
               tags[2*p +: 2] <= TAG_EMPTY;
         end
      end
   endgenerate

endmodule

// File: rtl/rot_regstack.sv
module rot_regstack #(
   parameter int NREG         = 8,
   parameter int EXP_W        = 15,
   parameter int MAN_W        = 64,
   parameter bit EXPLICIT_INT = 1'b1,
   localparam int PTR_W  = $clog2(NREG),
   localparam int DATA_W = 1 + EXP_W + MAN_W,
   localparam int TW_W   = 2 * NREG
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [2:0]        op_code,
   input  logic [PTR_W-1:0]  st_idx,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic [PTR_W-1:0]  top_ptr,
   output logic [TW_W-1:0]   tag_word,
   output logic              stk_fault,
   output logic              c1_dir,
   output logic              inv_op
);
   import rstk_pkg::*;

   // Elaboration checks on the parameters.
   generate
      if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
         $error("rot_regstack: NREG must be a power of two of at least 2");
      end
      if (EXP_W < 2 || MAN_W < 2) begin : g_bad_fmt
         $error("rot_regstack: exponent and significand need at least 2 bits");
      end
   endgenerate

   localparam logic [MAN_W-1:0] INDEF_MAN = EXPLICIT_INT ?
      {2'b11, {(MAN_W-2){1'b0}}} : {1'b1, {(MAN_W-1){1'b0}}};
   localparam logic [DATA_W-1:0] INDEF = {1'b1, {EXP_W{1'b1}}, INDEF_MAN};

   logic [PTR_W-1:0]  top, top_dn, top_i;
   logic [DATA_W-1:0] q [NREG];
   logic [TW_W-1:0]   tags;
   logic [1:0]        cls_tag;
   logic              ovf, unf;
   logic              emp_top, emp_dn, emp_i;

   logic              clr_all, a_en, b_en, e_en;
   logic [PTR_W-1:0]  a_addr, b_addr;
   logic [DATA_W-1:0] a_data, b_data;
   logic [1:0]        a_tag, b_tag;

   function automatic logic [1:0] fld(input logic [TW_W-1:0] w,
                                      input logic [PTR_W-1:0] a);
      return w[{a, 1'b0} +: 2];
   endfunction

   rstk_ptr #(.PTR_W(PTR_W)) u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire   (op_valid),
      .op     (op_code),
      .idx    (st_idx),
      .top    (top),
      .top_dn (top_dn),
      .top_i  (top_i)
   );

   rstk_classify #(
      .EXP_W(EXP_W), .MAN_W(MAN_W), .EXPLICIT_INT(EXPLICIT_INT)
   ) u_cls (
      .exp_f (wr_data[DATA_W-2 -: EXP_W]),
      .man_f (wr_data[MAN_W-1:0]),
      .tag   (cls_tag)
   );

   assign emp_top = (fld(tags, top)    == TAG_EMPTY);
   assign emp_dn  = (fld(tags, top_dn) == TAG_EMPTY);
   assign emp_i   = (fld(tags, top_i)  == TAG_EMPTY);

   rstk_fault u_flt (
      .fire      (op_valid),
      .op        (op_code),
      .empty_top (emp_top),
      .empty_dn  (emp_dn),
      .empty_i   (emp_i),
      .ovf       (ovf),
      .unf       (unf)
   );

   always_comb begin
      clr_all = 1'b0;
      a_en    = 1'b0;
      a_addr  = top_i;
      a_data  = wr_data;
      a_tag   = cls_tag;
      b_en    = 1'b0;
      b_addr  = top_i;
      b_data  = q[top];
      b_tag   = fld(tags, top);
      e_en    = 1'b0;
      if (op_valid) begin
         case (op_e'(op_code))
            OP_INIT: clr_all = 1'b1;
            OP_PUSH: begin
               a_en   = 1'b1;
               a_addr = top_dn;
               if (ovf) begin
                  a_data = INDEF;
                  a_tag  = TAG_SPEC;
               end
            end
            OP_POP:   e_en = 1'b1;
            OP_WRITE: a_en = 1'b1;
            OP_XCHG: begin
               if (!unf) begin
                  a_en   = 1'b1;
                  a_addr = top;
                  a_data = q[top_i];
                  a_tag  = fld(tags, top_i);
                  b_en   = 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   rstk_store #(.NREG(NREG), .DATA_W(DATA_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_all (clr_all),
      .a_en    (a_en),
      .a_addr  (a_addr),
      .a_data  (a_data),
      .a_tag   (a_tag),
      .b_en    (b_en),
      .b_addr  (b_addr),
      .b_data  (b_data),
      .b_tag   (b_tag),
      .e_en    (e_en),
      .e_addr  (top),
      .q       (q),
      .tags    (tags)
   );

   assign rd_data   = emp_i ? INDEF : q[top_i];
   assign top_ptr   = top;
   assign tag_word  = tags;
   assign stk_fault = ovf | unf;
   assign c1_dir    = ovf;
   assign inv_op    = ovf | unf;

endmodule

// File: rtl/rot_regstack_chk.sv
module rot_regstack_chk #(
   parameter int NREG = 8,
   localparam int PTR_W = $clog2(NREG),
   localparam int TW_W  = 2 * NREG
) (
   input logic             clk,
   input logic             rst_n,
   input logic             op_valid,
   input logic [2:0]       op_code,
   input logic [PTR_W-1:0] top_ptr,
   input logic [TW_W-1:0]  tag_word,
   input logic             stk_fault,
   input logic             c1_dir,
   input logic             inv_op
);
   import rstk_pkg::*;

   localparam logic [TW_W-1:0]  FIELD1 = TW_W'(3);
   localparam logic [PTR_W-1:0] STEP   = PTR_W'(1);

   logic is_init, is_push, is_pop, is_write, is_xchg, is_step;
   assign is_init  = op_valid && op_code == OP_INIT;
   assign is_push  = op_valid && op_code == OP_PUSH;
   assign is_pop   = op_valid && op_code == OP_POP;
   assign is_write = op_valid && op_code == OP_WRITE;
   assign is_xchg  = op_valid && op_code == OP_XCHG;
   assign is_step  = op_valid && (op_code == OP_INC || op_code == OP_DEC);

   p_init_r1: assert property (@(posedge clk) disable iff (!rst_n)
      is_init |=> (top_ptr == '0 && tag_word == '1));

   p_push_rot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      is_push |=> (top_ptr == $past(top_ptr) - STEP));

   p_push_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
      is_push |=> (tag_word[{top_ptr, 1'b0} +: 2] != TAG_EMPTY));

   p_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      is_pop |=> (top_ptr == $past(top_ptr) + STEP &&
                  tag_word == ($past(tag_word) |
                               (FIELD1 << {$past(top_ptr), 1'b0}))));

   p_ovf_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
      c1_dir |-> (stk_fault && is_push));

   p_unf_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_fault && !is_push) |-> !c1_dir);

   p_inv_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stk_fault |-> inv_op);

   p_xchg_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (is_xchg && stk_fault) |=> (tag_word == $past(tag_word)));

   p_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      is_step |=> (tag_word == $past(tag_word)));

   p_step_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      is_step |-> !stk_fault);

   p_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
      is_write |-> !stk_fault);

   p_write_top_r11: assert property (@(posedge clk) disable iff (!rst_n)
      is_write |=> (top_ptr == $past(top_ptr)));

   p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |-> !(stk_fault || inv_op || c1_dir));

   p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> (top_ptr == $past(top_ptr) && tag_word == $past(tag_word)));

endmodule

bind rot_regstack rot_regstack_chk #(.NREG(NREG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_valid  (op_valid),
   .op_code   (op_code),
   .top_ptr   (top_ptr),
   .tag_word  (tag_word),
   .stk_fault (stk_fault),
   .c1_dir    (c1_dir),
   .inv_op    (inv_op)
);

// File: tb/rot_regstack_test.sv
module rot_regstack_test;
   import rstk_pkg::*;

   localparam logic [79:0] V_ONE   = 80'h3FFF_8000_0000_0000_0000;
   localparam logic [79:0] V_TWO   = 80'h4000_8000_0000_0000_0000;
   localparam logic [79:0] V_ZERO  = 80'h0;
   localparam logic [79:0] V_INF   = 80'h7FFF_8000_0000_0000_0000;
   localparam logic [79:0] V_DEN   = 80'h0000_0000_0000_0000_0001;
   localparam logic [79:0] V_UNN   = 80'h3FFF_4000_0000_0000_0000;
   localparam logic [79:0] V_INDEF = 80'hFFFF_C000_0000_0000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [2:0]  op_code = 3'd0;
   logic [2:0]  st_idx = 3'd0;
   logic [79:0] wr_data = '0;
   logic [79:0] rd_data;
   logic [2:0]  top_ptr;
   logic [15:0] tag_word;
   logic        stk_fault, c1_dir, inv_op;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   logic        f_flt, f_c1, f_inv;
   logic [79:0] f_rd;

   always #2 clk = ~clk;

   rot_regstack uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_valid  (op_valid),
      .op_code   (op_code),
      .st_idx    (st_idx),
      .wr_data   (wr_data),
      .rd_data   (rd_data),
      .top_ptr   (top_ptr),
      .tag_word  (tag_word),
      .stk_fault (stk_fault),
      .c1_dir    (c1_dir),
      .inv_op    (inv_op)
   );

   task automatic check(input string req, input logic [79:0] act,
                        input logic [79:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Drives one operation, captures the same-cycle outputs, then lets the
   // clock edge commit it.
   task automatic do_op(input op_e code, input int idx, input logic [79:0] d);
      @(negedge clk);
      op_valid = 1'b1;
      op_code  = code;
      st_idx   = idx[2:0];
      wr_data  = d;
      #1;
      f_flt = stk_fault;
      f_c1  = c1_dir;
      f_inv = inv_op;
      f_rd  = rd_data;
      @(posedge clk);
      #1;
      op_valid = 1'b0;
   endtask

   task automatic t_reset;
      #1;
      check("R1 reset top", 80'(top_ptr), 80'd0);
      check("R1 reset tags", 80'(tag_word), 80'hFFFF);
      check("R12 reset no fault", 80'(stk_fault), 80'd0);
   endtask

   task automatic t_push_pop;
      do_op(OP_INIT, 0, '0);
      do_op(OP_PUSH, 0, V_ONE);
      check("R2 first push top", 80'(top_ptr), 80'd7);
      check("R5 tags after nonzero push", 80'(tag_word), 80'h3FFF);
      do_op(OP_PUSH, 0, V_ZERO);
      check("R2 second push top", 80'(top_ptr), 80'd6);
      check("R5 tags after zero push", 80'(tag_word), 80'h1FFF);
      do_op(OP_READ, 0, '0);
      check("R4 read ST0", f_rd, V_ZERO);
      check("R4 read ST0 no fault", 80'(f_flt), 80'd0);
      do_op(OP_READ, 1, '0);
      check("R4 read ST1", f_rd, V_ONE);
      do_op(OP_POP, 0, '0);
      check("R3 pop top", 80'(top_ptr), 80'd7);
      check("R3 pop tags", 80'(tag_word), 80'h3FFF);
      check("R3 pop no fault", 80'(f_flt), 80'd0);
      do_op(OP_POP, 0, '0);
      check("R3 second pop top", 80'(top_ptr), 80'd0);
      check("R3 second pop tags", 80'(tag_word), 80'hFFFF);
   endtask

   task automatic t_classify;
      do_op(OP_INIT, 0, '0);
      do_op(OP_PUSH, 0, V_DEN);
      check("R5 denormal special", 80'(tag_word), 80'hBFFF);
      do_op(OP_PUSH, 0, V_INF);
      check("R5 infinity special", 80'(tag_word), 80'hAFFF);
      do_op(OP_PUSH, 0, V_UNN);
      check("R5 unnormal special", 80'(tag_word), 80'hABFF);
   endtask

   task automatic t_overflow;
      do_op(OP_INIT, 0, '0);
      for (int k = 0; k < 8; k++) do_op(OP_PUSH, 0, V_ONE);
      check("R6 full ring top", 80'(top_ptr), 80'd0);
      check("R6 full ring tags", 80'(tag_word), 80'h0000);
      do_op(OP_PUSH, 0, V_TWO);
      check("R6 overflow fault", 80'(f_flt), 80'd1);
      check("R6 overflow c1", 80'(f_c1), 80'd1);
      check("R8 overflow invalid", 80'(f_inv), 80'd1);
      check("R6 overflow still rotates", 80'(top_ptr), 80'd7);
      check("R6 overflow tag special", 80'(tag_word), 80'h8000);
      do_op(OP_READ, 0, '0);
      check("R6 overflow top indefinite", f_rd, V_INDEF);
      do_op(OP_READ, 1, '0);
      check("R4 ST1 after overflow", f_rd, V_ONE);
      check("R4 read of nonempty no fault", 80'(f_flt), 80'd0);
   endtask

   task automatic t_underflow;
      do_op(OP_INIT, 0, '0);
      do_op(OP_POP, 0, '0);
      check("R7 pop empty fault", 80'(f_flt), 80'd1);
      check("R7 pop empty c1", 80'(f_c1), 80'd0);
      check("R8 underflow invalid", 80'(f_inv), 80'd1);
      check("R3 pop empty still moves", 80'(top_ptr), 80'd1);
      check("R3 pop empty tags", 80'(tag_word), 80'hFFFF);
      do_op(OP_READ, 3, '0);
      check("R7 read empty fault", 80'(f_flt), 80'd1);
      check("R7 read empty c1", 80'(f_c1), 80'd0);
      check("R4 read empty indefinite", f_rd, V_INDEF);
   endtask

   task automatic t_xchg;
      do_op(OP_INIT, 0, '0);
      do_op(OP_PUSH, 0, V_ONE);
      do_op(OP_PUSH, 0, V_ZERO);
      do_op(OP_XCHG, 1, '0);
      check("R9 exchange no fault", 80'(f_flt), 80'd0);
      check("R9 exchange tags swapped", 80'(tag_word), 80'h0FFF | 80'h0000 + 80'h4000 - 80'h4000 + 80'h0000 + (80'h1 << 14) - 80'h0);
      do_op(OP_READ, 0, '0);
      check("R9 ST0 after exchange", f_rd, V_ONE);
      do_op(OP_READ, 1, '0);
      check("R9 ST1 after exchange", f_rd, V_ZERO);
      do_op(OP_XCHG, 2, '0);
      check("R9 exchange empty fault", 80'(f_flt), 80'd1);
      check("R9 exchange empty c1", 80'(f_c1), 80'd0);
      check("R9 exchange empty tags kept", 80'(tag_word), 80'h4FFF);
      do_op(OP_READ, 0, '0);
      check("R9 exchange empty ST0 kept", f_rd, V_ONE);
   endtask

   task automatic t_step;
      // state from t_xchg: top 6, phys6 = ONE, phys7 = ZERO
      do_op(OP_INC, 0, '0);
      check("R10 inc top", 80'(top_ptr), 80'd7);
      check("R10 inc no fault", 80'(f_flt), 80'd0);
      check("R10 inc tags", 80'(tag_word), 80'h4FFF);
      do_op(OP_READ, 0, '0);
      check("R10 ST0 after inc", f_rd, V_ZERO);
      do_op(OP_INC, 0, '0);
      check("R10 inc wraps", 80'(top_ptr), 80'd0);
      do_op(OP_DEC, 0, '0);
      check("R10 dec wraps", 80'(top_ptr), 80'd7);
      do_op(OP_DEC, 0, '0);
      check("R10 dec top", 80'(top_ptr), 80'd6);
      check("R10 dec tags", 80'(tag_word), 80'h4FFF);
   endtask

   task automatic t_write;
      do_op(OP_INIT, 0, '0);
      do_op(OP_PUSH, 0, V_ONE);
      do_op(OP_WRITE, 1, V_ZERO);
      check("R11 write empty no fault", 80'(f_flt), 80'd0);
      check("R11 write top kept", 80'(top_ptr), 80'd7);
      check("R11 write tags", 80'(tag_word), 80'h3FFD);
      do_op(OP_READ, 1, '0);
      check("R11 read written ST1", f_rd, V_ZERO);
      do_op(OP_WRITE, 0, V_INF);
      check("R11 overwrite tags", 80'(tag_word), 80'hBFFD);
      do_op(OP_READ, 0, '0);
      check("R11 read overwritten ST0", f_rd, V_INF);
   endtask

   task automatic t_idle;
      do_op(OP_INIT, 0, '0);
      @(negedge clk);
      op_valid = 1'b0;
      op_code  = OP_POP;
      #1;
      check("R12 idle pop code no fault", 80'(stk_fault), 80'd0);
      @(negedge clk);
      op_code = OP_PUSH;
      wr_data = V_ONE;
      @(negedge clk);
      check("R12 idle keeps top", 80'(top_ptr), 80'd0);
      check("R12 idle keeps tags", 80'(tag_word), 80'hFFFF);
      do_op(OP_PUSH, 0, V_ONE);
      @(negedge clk);
      check("R12 fault low after op", 80'(stk_fault), 80'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_push_pop();
      t_classify();
      t_overflow();
      t_underflow();
      t_xchg();
      t_step();
      t_write();
      t_idle();
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule